// File: doc/BRIEF.md
# Width-Converting Two-Phase Transfer Engine

This block is the datapath and sequencer for a memory-to-memory copy that moves data in two phases. It first reads from the source into an internal holding register. It then writes that register's contents to the destination in later cycles. The source side and the destination side each have their own bus width of 8, 16 or 32 bits. The engine therefore packs several narrow reads into one wide write, or splits one wide read into several narrow writes.

A copy begins with a one-cycle `start_i` pulse. That pulse carries the two start addresses, the two width codes and a byte count. The engine then drives a single-beat memory master port until every byte has been written. At the end it pulses `done_o`. Bad parameters are rejected with an `err_o` pulse, and no bus activity follows.

Top module: `xfer_pack_engine`

## Requirements
- R1: After reset the engine is idle: `busy_o`, `mem_req_o`, `done_o` and `err_o` are all low.
- R2: When `start_i` is accepted with valid parameters, the cycle that follows shows a read request (`mem_we_o`=0) at the source start address with `mem_size_o` equal to the source width code.
- R3: Width codes are 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, and code 3 is invalid. A start is rejected in three cases: either width code is 3, the byte count is zero, or the byte count is not a multiple of the larger width in bytes. On a rejected start, `err_o` pulses for one cycle in the cycle after the start, `busy_o` stays low and no request is made.
- R4: Read data arrives right-aligned in `mem_rdata_i`, and bits above the source width are ignored. When packing, the k-th read of a group fills bytes k*S to k*S+S-1 of the holding word, where S is the source width in bytes, so the earliest read lands in the least significant lane. The write that follows carries the gathered word.
- R5: When unpacking, one wide read is followed by several narrow writes. Write j of a group drives bytes j*D to j*D+D-1 of the read word, right-aligned in `mem_wdata_o`, where D is the destination width in bytes. The least significant lane goes first.
- R6: The source address advances by the source width after each accepted read. The destination address advances by the destination width after each accepted write.
- R7: A request holds its address, size, direction and write data unchanged until `mem_ready_i` is high. Nothing advances while `mem_ready_i` is low.
- R8: Each group of max(S,D) bytes is handled as all its reads followed by all its writes. A copy of N bytes makes N/S reads and N/D writes in total.
- R9: `done_o` pulses for one cycle in the cycle after the final write is accepted, and `busy_o` is low in that same cycle.
- R10: A `start_i` pulse that arrives while a copy is running is ignored, and the running copy continues unchanged.
- R11: When both widths are equal, reads and writes alternate one for one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a copy |
| src_addr_i | input | AW | Source start byte address |
| dst_addr_i | input | AW | Destination start byte address |
| src_size_i | input | 2 | Source width code |
| dst_size_i | input | 2 | Destination width code |
| len_i | input | LW | Byte count |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle parameter-rejection pulse |
| mem_req_o | output | 1 | Bus request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access byte address |
| mem_size_o | output | 2 | Access width code |
| mem_wdata_o | output | 32 | Write data, right-aligned |
| mem_rdata_i | input | 32 | Read data, right-aligned |
| mem_ready_i | input | 1 | Access accepted this cycle |

## Verification
The first request is due one cycle after an accepted start. A rejection pulse is due one cycle after a rejected start. The completion pulse is due one cycle after the handshake of the last write, and every later access is due one cycle after the handshake of the one before it. The bench builds the whole ordered list of expected accesses from the source bytes. At each falling edge it compares the port state against the head of that list, and it only removes the head when it drives ready itself. This makes stalls, ordering and the completion cycle all exact, including under throttled ready.

// File: rtl/xpe_pkg.sv
package xpe_pkg;

  localparam int XPE_DW = 32;

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_BAD = 2'd3
  } xpe_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xpe_state_e;

  // Bytes per access for a width code (0 for the invalid code)
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] wider_code(input logic [1:0] a, input logic [1:0] b);
    return (a > b) ? a : b;
  endfunction

  // Index of the last beat on one side within a group of the wider width
  function automatic logic [1:0] last_beat(input logic [1:0] own, input logic [1:0] other);
    logic [2:0] beats;
    beats = 3'd1 << (wider_code(own, other) - own);
    return 2'(beats - 3'd1);
  endfunction

  // Place a right-aligned read into lane idx of the holding word
  function automatic logic [XPE_DW-1:0] lane_insert(input logic [XPE_DW-1:0] hold,
                                                    input logic [XPE_DW-1:0] data,
                                                    input logic [1:0] idx,
                                                    input logic [1:0] code);
    logic [XPE_DW-1:0] res;
    res = hold;
    for (int b = 0; b < 4; b++) begin
      if ((2'(b) >> code) == idx)
        res[b*8 +: 8] = data[(b & (int'(size_bytes(code)) - 1))*8 +: 8];
    end
    return res;
  endfunction

  // Pull lane idx of the holding word out, right-aligned, upper bytes zero
  function automatic logic [XPE_DW-1:0] lane_extract(input logic [XPE_DW-1:0] hold,
                                                     input logic [1:0] idx,
                                                     input logic [1:0] code);
    logic [XPE_DW-1:0] res;
    int base;
    res  = '0;
    base = int'(idx) << code;
    for (int m = 0; m < 4; m++) begin
      if (m < int'(size_bytes(code)) && (base + m) < 4)
        res[m*8 +: 8] = hold[(base + m)*8 +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/xpe_cfg_check.sv
module xpe_cfg_check #(
  parameter int LW = 16
) (
  input  logic [1:0]    src_size_i,
  input  logic [1:0]    dst_size_i,
  input  logic [LW-1:0] len_i,
  output logic          cfg_ok_o
);
  import xpe_pkg::*;

  logic [LW-1:0] grp_mask;
  logic          sizes_ok;

  always_comb begin
    sizes_ok = (src_size_i != SZ_BAD) && (dst_size_i != SZ_BAD);
    grp_mask = LW'(size_bytes(wider_code(src_size_i, dst_size_i))) - LW'(1);
    cfg_ok_o = sizes_ok && (len_i != '0) && ((len_i & grp_mask) == '0);
  end

endmodule

// File: rtl/xpe_addr_gen.sv
module xpe_addr_gen #(
  parameter int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          step_i,
  input  logic [1:0]    code_i,
  output logic [AW-1:0] addr_o
);
  import xpe_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_o <= '0;
    else if (load_i) addr_o <= load_addr_i;
    else if (step_i) addr_o <= addr_o + AW'(size_bytes(code_i));
  end

  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (addr_o == $past(addr_o) + AW'(size_bytes($past(code_i)))));

endmodule

// File: rtl/xpe_hold_reg.sv
module xpe_hold_reg (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cap_i,
  input  logic [31:0] rdata_i,
  input  logic [1:0]  rd_idx_i,
  input  logic [1:0]  src_code_i,
  input  logic [1:0]  wr_idx_i,
  input  logic [1:0]  dst_code_i,
  output logic [31:0] wdata_o
);
  import xpe_pkg::*;

  logic [XPE_DW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hold_q <= '0;
    else if (cap_i) hold_q <= lane_insert(hold_q, rdata_i, rd_idx_i, src_code_i);
  end

  assign wdata_o = lane_extract(hold_q, wr_idx_i, dst_code_i);

endmodule

// File: rtl/xpe_seq.sv
module xpe_seq #(
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cfg_ok_i,
  input  logic [1:0]    src_size_i,
  input  logic [1:0]    dst_size_i,
  input  logic [LW-1:0] len_i,
  input  logic          ready_i,
  output xpe_pkg::xpe_state_e state_o,
  output logic [1:0]    src_code_o,
  output logic [1:0]    dst_code_o,
  output logic [1:0]    rd_idx_o,
  output logic [1:0]    wr_idx_o,
  output logic          load_o,
  output logic          rd_acc_o,
  output logic          wr_acc_o,
  output logic          done_o,
  output logic          err_o
);
  import xpe_pkg::*;

  xpe_state_e    state_q;
  logic [LW-1:0] left_q;
  logic [LW-1:0] dst_step;
  logic [1:0]    rd_last, wr_last;
  logic          accept;

  assign accept   = start_i && (state_q == ST_IDLE);
  assign load_o   = accept && cfg_ok_i;
  assign rd_acc_o = (state_q == ST_READ) && ready_i;
  assign wr_acc_o = (state_q == ST_WRITE) && ready_i;
  assign rd_last  = last_beat(src_code_o, dst_code_o);
  assign wr_last  = last_beat(dst_code_o, src_code_o);
  assign dst_step = LW'(size_bytes(dst_code_o));
  assign state_o  = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      left_q     <= '0;
      src_code_o <= 2'd0;
      dst_code_o <= 2'd0;
      rd_idx_o   <= 2'd0;
      wr_idx_o   <= 2'd0;
      done_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (cfg_ok_i) begin
              state_q    <= ST_READ;
              left_q     <= len_i;
              src_code_o <= src_size_i;
              dst_code_o <= dst_size_i;
              rd_idx_o   <= 2'd0;
              wr_idx_o   <= 2'd0;
            end else begin
              err_o <= 1'b1;
            end
          end
        end
        ST_READ: begin
          if (rd_acc_o) begin
            if (rd_idx_o == rd_last) begin
              rd_idx_o <= 2'd0;
              state_q  <= ST_WRITE;
            end else begin
              rd_idx_o <= rd_idx_o + 2'd1;
            end
          end
        end
        ST_WRITE: begin
          if (wr_acc_o) begin
            left_q <= left_q - dst_step;
            if (wr_idx_o == wr_last) begin
              wr_idx_o <= 2'd0;
              if (left_q == dst_step) begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
              end else begin
                state_q <= ST_READ;
              end
            end else begin
              wr_idx_o <= wr_idx_o + 2'd1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (state_q == ST_IDLE) && $past(wr_acc_o));

  // R3
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (state_q == ST_IDLE) && $past(start_i) && !$past(cfg_ok_i));

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |=> $stable(src_code_o) && $stable(dst_code_o));

  // R8
  left_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) |-> (left_q != '0));

endmodule

// File: rtl/xfer_pack_engine.sv
module xfer_pack_engine #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] src_addr_i,
  input  logic [AW-1:0] dst_addr_i,
  input  logic [1:0]    src_size_i,
  input  logic [1:0]    dst_size_i,
  input  logic [LW-1:0] len_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [1:0]    mem_size_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  input  logic          mem_ready_i
);
  import xpe_pkg::*;

  logic          cfg_ok;
  xpe_state_e    state;
  logic [1:0]    src_code, dst_code, rd_idx, wr_idx;
  logic          load_ev, rd_acc_ev, wr_acc_ev;
  logic [AW-1:0] src_addr, dst_addr;
  logic [31:0]   wdata;

  xpe_cfg_check #(.LW(LW)) u_cfg (
    .src_size_i (src_size_i),
    .dst_size_i (dst_size_i),
    .len_i      (len_i),
    .cfg_ok_o   (cfg_ok)
  );

  xpe_seq #(.LW(LW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cfg_ok_i   (cfg_ok),
    .src_size_i (src_size_i),
    .dst_size_i (dst_size_i),
    .len_i      (len_i),
    .ready_i    (mem_ready_i),
    .state_o    (state),
    .src_code_o (src_code),
    .dst_code_o (dst_code),
    .rd_idx_o   (rd_idx),
    .wr_idx_o   (wr_idx),
    .load_o     (load_ev),
    .rd_acc_o   (rd_acc_ev),
    .wr_acc_o   (wr_acc_ev),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  xpe_addr_gen #(.AW(AW)) u_src_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_ev),
    .load_addr_i (src_addr_i),
    .step_i      (rd_acc_ev),
    .code_i      (src_code),
    .addr_o      (src_addr)
  );

  xpe_addr_gen #(.AW(AW)) u_dst_addr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_ev),
    .load_addr_i (dst_addr_i),
    .step_i      (wr_acc_ev),
    .code_i      (dst_code),
    .addr_o      (dst_addr)
  );

  xpe_hold_reg u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (rd_acc_ev),
    .rdata_i    (mem_rdata_i),
    .rd_idx_i   (rd_idx),
    .src_code_i (src_code),
    .wr_idx_i   (wr_idx),
    .dst_code_i (dst_code),
    .wdata_o    (wdata)
  );

  assign busy_o      = (state != ST_IDLE);
  assign mem_req_o   = (state == ST_READ) || (state == ST_WRITE);
  assign mem_we_o    = (state == ST_WRITE);
  assign mem_addr_o  = mem_we_o ? dst_addr : src_addr;
  assign mem_size_o  = mem_we_o ? dst_code : src_code;
  assign mem_wdata_o = mem_we_o ? wdata : '0;

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_size_o) && $stable(mem_wdata_o));

  // R2
  first_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && cfg_ok) |=> mem_req_o && !mem_we_o
                                      && (mem_addr_o == $past(src_addr_i))
                                      && (mem_size_o == $past(src_size_i)));

  // R9
  done_err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o) && !(done_o && busy_o));

  // R3
  err_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !mem_req_o);

endmodule

// File: tb/xfer_pack_engine_tb.sv
module xfer_pack_engine_tb_top;

  localparam int AW = 32;
  localparam int LW = 16;

  typedef struct {
    bit        we;
    bit [31:0] addr;
    bit [1:0]  sz;
    bit [31:0] data;
  } acc_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] src_addr = '0, dst_addr = '0;
  logic [1:0]    src_size = '0, dst_size = '0;
  logic [LW-1:0] len = '0;
  logic          busy, done, err, req, we;
  logic [AW-1:0] addr;
  logic [1:0]    size;
  logic [31:0]   wdata;
  logic [31:0]   rdata = '0;
  logic          ready = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  acc_t exp_q[$];

  always #2 clk = ~clk;

  xfer_pack_engine #(.AW(AW), .LW(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .src_addr_i(src_addr), .dst_addr_i(dst_addr),
    .src_size_i(src_size), .dst_size_i(dst_size), .len_i(len),
    .busy_o(busy), .done_o(done), .err_o(err),
    .mem_req_o(req), .mem_we_o(we), .mem_addr_o(addr), .mem_size_o(size),
    .mem_wdata_o(wdata), .mem_rdata_i(rdata), .mem_ready_i(ready)
  );

  function automatic bit [7:0] mem_byte(input bit [31:0] a);
    return 8'((a * 13) + (a >> 4) + 5);
  endfunction

  function automatic int nbytes(input int code);
    return 1 << code;
  endfunction

  function automatic bit [31:0] gather(input bit [31:0] a, input int n);
    bit [31:0] v = 32'h0;
    for (int m = 0; m < n; m++) v[m*8 +: 8] = mem_byte(a + 32'(m));
    return v;
  endfunction

  task automatic check(input bit ok, input string req_tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req_tag, what, act, expv);
    end
  endtask

  // Expected access list: the copy moves source byte i to destination byte i
  task automatic build(input int s, input int d, input int ss, input int ds, input int n);
    int sb = nbytes(ss);
    int db = nbytes(ds);
    int g  = (sb > db) ? sb : db;
    acc_t e;
    exp_q.delete();
    for (int grp = 0; grp < n / g; grp++) begin
      for (int k = 0; k < g / sb; k++) begin
        e.we = 0; e.addr = 32'(s + grp*g + k*sb); e.sz = 2'(ss); e.data = '0;
        exp_q.push_back(e);
      end
      for (int j = 0; j < g / db; j++) begin
        e.we = 1; e.addr = 32'(d + grp*g + j*db); e.sz = 2'(ds);
        e.data = gather(32'(s + grp*g + j*db), db);
        exp_q.push_back(e);
      end
    end
  endtask

  task automatic run_xfer(input string tag, input int s, input int d, input int ss,
                          input int ds, input int n, input int rmode, input bit poke);
    int cyc = 0;
    bit ended = 0;
    acc_t h;
    bit ok;
    build(s, d, ss, ds, n);
    @(negedge clk);
    start = 1; src_addr = 32'(s); dst_addr = 32'(d);
    src_size = 2'(ss); dst_size = 2'(ds); len = LW'(n);
    @(negedge clk);
    start = 0;
    while (!ended && cyc < 2000) begin
      // R10: a second start while busy must not disturb the expected stream
      if (poke && cyc == 2) begin
        start = 1; src_addr = 32'h9000; src_size = 2'd0; len = 16'd4;
      end else begin
        start = 0;
      end
      if (exp_q.size() > 0) begin
        h = exp_q[0];
        ok = req && (we == h.we) && (addr == h.addr) && (size == h.sz)
             && (!h.we || wdata == h.data) && !done;
        check(ok, tag, h.we ? "write access" : "read access",
              {req, we, size, addr[28:0], wdata}, {1'b1, h.we, h.sz, h.addr[28:0], h.data});
        ready = (rmode == 0) ? 1'b1 : ((cyc % 3) != 1);
        if (!h.we) rdata = (gather(h.addr, nbytes(ss)) | (32'hA5A5A5A5 << (8*nbytes(ss) % 32)))
                           & ((ss == 2) ? 32'hFFFFFFFF : 32'hFFFFFFFF);
        if (!h.we && ss != 2) rdata = gather(h.addr, nbytes(ss)) | (32'hA5A5A5A5 << (8*nbytes(ss)));
        if (!h.we && ss == 2) rdata = gather(h.addr, 4);
        if (ready) void'(exp_q.pop_front());
      end else begin
        ready = 0;
        rdata = 32'hDEADBEEF;
        // R9: done pulse with busy low one cycle after the final write
        check(done && !busy && !req, "R9", "completion", {done, busy, req}, 3'b100);
        ended = 1;
      end
      cyc++;
      @(negedge clk);
    end
    start = 0;
    ready = 0;
    check(ended, tag, "transfer finished", 64'(ended), 64'd1);
    check(!done && !busy, "R9", "done is a single pulse", {done, busy}, 2'b00);
  endtask

  task automatic run_bad(input int ss, input int ds, input int n);
    @(negedge clk);
    start = 1; src_addr = 32'h40; dst_addr = 32'h80;
    src_size = 2'(ss); dst_size = 2'(ds); len = LW'(n);
    @(negedge clk);
    start = 0;
    // R3: rejection pulse the cycle after start, no bus activity
    check(err && !busy && !req && !done, "R3", "reject pulse", {err, busy, req, done}, 4'b1000);
    @(negedge clk);
    check(!err && !busy && !req, "R3", "reject aftermath", {err, busy, req}, 3'b000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(!busy && !req && !done && !err, "R1", "reset state", {busy, req, done, err}, 4'b0000);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !req && !done && !err, "R1", "idle after reset", {busy, req, done, err}, 4'b0000);

    run_xfer("R4", 32'h100, 32'h200, 1, 2, 16, 0, 0);   // two 16-bit reads per 32-bit write
    run_xfer("R4", 32'h301, 32'h400, 0, 2, 8, 1, 0);    // four byte reads, throttled ready (R7)
    run_xfer("R5", 32'h500, 32'h603, 2, 0, 8, 0, 0);    // one word read, four byte writes
    run_xfer("R5", 32'h700, 32'h802, 2, 1, 12, 1, 0);   // word to halfwords, throttled (R7)
    run_xfer("R11", 32'h905, 32'hA07, 0, 0, 3, 0, 0);   // equal widths alternate
    run_xfer("R10", 32'hB00, 32'hC00, 1, 1, 8, 0, 1);   // start ignored while busy
    run_xfer("R8", 32'hD00, 32'hE00, 0, 1, 10, 1, 0);   // byte to halfword packing, R6 addresses
    run_xfer("R2", 32'hF00, 32'hF40, 2, 2, 8, 1, 0);

    run_bad(2, 0, 6);   // not a multiple of 4
    run_bad(3, 1, 8);   // invalid width code
    run_bad(1, 1, 0);   // zero length
    run_bad(0, 1, 3);   // not a multiple of 2

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule